// File: doc/BRIEF.md
# MSI Capability Interrupt Selector

This block holds the Message Signaled Interrupt capability words of one port and decides how each interrupt event is delivered. Software reaches the words through a small register port. That port takes a byte offset, 32-bit write data with byte enables, and returns combinational read data. Two doublewords are visible. The first holds the capability identifier and next-pointer bytes in its low half and the message control word in its high half. The second holds the message address.

Interrupt events arrive on a level input, and only their rising edges count. The port's bus-master enable is an input. When MSI is enabled and bus mastering is permitted, each edge becomes a one-cycle write request that carries the programmed address. An acknowledge input retires the request. When MSI is disabled, an edge sets a sticky legacy interrupt pin instead. If MSI is enabled but bus mastering is not, the event is dropped.

Only single-vector, 32-bit messages are produced. The multiple-message enable field is stored for software and has no effect on delivery.

Top module: `msi_cap_sel`

## Requirements
- R1: After reset, a read at offset 80h returns 0000_9005h and a read at offset 84h returns 0000_0000h.
- R2: Bits 15:0 of doubleword 80h are read-only. They hold 05h (the MSI identifier) in bits 7:0 and 90h (the next-capability pointer) in bits 15:8, and writes leave them unchanged.
- R3: In doubleword 80h, bits 31:24, bit 23 (64-bit capability) and bits 19:17 (vector capability) always read 0, whatever is written.
- R4: Bits 22:20 (multiple-message enable) are read/write through byte enable 2. For every value of this field, one event produces exactly one request.
- R5: Bit 16 of doubleword 80h is the MSI enable. It is read/write through byte enable 2.
- R6: At offset 84h, address bits 31:2 are writable byte by byte under the four byte enables. Bits 1:0 always read 0, and every request address is DWord aligned.
- R7: Reads at any doubleword other than 80h and 84h return 0, and writes there change no register.
- R8: With MSI enable and bus-master enable both 1, a rising event edge sampled at a clock edge makes `msi_req_o` high for exactly the next cycle. `msi_addr_o` carries the programmed address during that cycle.
- R9: Edges that arrive while a request is still unacknowledged merge into one pending request. That request is issued in the cycle after the acknowledge.
- R10: With MSI enable 1 and bus-master enable 0, an event produces neither a request nor a pin assertion.
- R11: With MSI enable 0, an event sets `intx_o` from the next cycle on. The pin then stays high until `irq_clr_i` is pulsed, regardless of bus-master enable, and never produces a request.
- R12: While MSI enable is 1, `intx_o` is 0 from the cycle after the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_off_i | input | 8 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte enables for the write |
| reg_rdata_o | output | 32 | Read data for `reg_off_i` |
| bme_i | input | 1 | Bus-master enable of the port |
| irq_evt_i | input | 1 | Interrupt event level; its rising edges count |
| irq_clr_i | input | 1 | Clears the legacy pin |
| msi_ack_i | input | 1 | Acknowledges the outstanding request |
| msi_req_o | output | 1 | One-cycle MSI write request |
| msi_addr_o | output | 32 | Address carried by the request |
| intx_o | output | 1 | Legacy interrupt pin |

## Verification
The register side is swept over every doubleword offset from 00h to FCh. Each offset is hit with an all-ones write and then read, which separates the live fields from the read-only and reserved bits and from unmapped space. The multiple-message field is stepped through all eight values, with one event per value, to show that delivery is the same for each. The address is written with single byte enables and then full patterns, which exposes byte-lane mixups and alignment leaks. Events are delivered under all four combinations of MSI enable and bus-master enable. Bursts of edges before an acknowledge tell merging apart from both losing and duplicating requests.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned OFF_W    = 8;
  localparam logic [OFF_W-1:0] OFF_CTRL = 8'h80;
  localparam logic [OFF_W-1:0] OFF_ADDR = 8'h84;
  localparam logic [7:0] ID_MSI    = 8'h05;
  localparam logic [7:0] NEXT_CAP  = 8'h90;
  localparam int unsigned MME_W    = 3;

  typedef struct packed {
    logic [MME_W-1:0] mme;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] addr_o
);
  localparam int unsigned DW_LSB = 2;

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:DW_LSB] addr_q, addr_d;
  logic              hit_ctrl, hit_addr;

  assign hit_ctrl = (off_i[OFF_W-1:DW_LSB] == OFF_CTRL[OFF_W-1:DW_LSB]);
  assign hit_addr = (off_i[OFF_W-1:DW_LSB] == OFF_ADDR[OFF_W-1:DW_LSB]);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i && hit_ctrl && be_i[2]) begin
      ctrl_d.mme = wdata_i[20 +: MME_W];
      ctrl_d.en  = wdata_i[16];
    end
  end

  // Each byte lane of the address register has its own write enable.
  for (genvar b = 0; b < BE_W; b++) begin : g_addr_lane
    localparam int unsigned LO = (b == 0) ? DW_LSB : 8*b;
    always_comb begin
      addr_d[8*b+7:LO] = addr_q[8*b+7:LO];
      if (wr_i && hit_addr && be_i[b]) addr_d[8*b+7:LO] = wdata_i[8*b+7:LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)
      rdata_o = {8'h00, 1'b0, ctrl_q.mme, 3'b000, ctrl_q.en, NEXT_CAP, ID_MSI};
    else if (hit_addr)
      rdata_o = {addr_q, 2'b00};
  end

  assign ctrl_o = ctrl_q;
  assign addr_o = {addr_q, 2'b00};
endmodule

// File: rtl/msi_cap_deliver.sv
module msi_cap_deliver
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_en_i,
  input  logic              bme_i,
  input  logic              evt_i,
  input  logic              clr_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic              req_o,
  output logic [DATA_W-1:0] req_addr_o,
  output logic              intx_o
);
  logic evt_q, busy_q, pend_q, req_q, intx_q;
  logic busy_d, pend_d, req_d, intx_d;
  logic [DATA_W-1:0] raddr_q, raddr_d;
  logic rise, msi_ok, free;

  assign rise   = evt_i & ~evt_q;
  assign msi_ok = msi_en_i & bme_i;
  assign free   = ~busy_q | ack_i;

  always_comb begin
    req_d   = free & msi_ok & (pend_q | rise);
    pend_d  = msi_en_i & (free ? (pend_q & rise & msi_ok)
                               : (pend_q | (rise & msi_ok)));
    busy_d  = req_d | (busy_q & ~ack_i);
    raddr_d = req_d ? addr_i : raddr_q;
    intx_d  = ~msi_en_i & (rise | (intx_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
      intx_q  <= 1'b0;
      raddr_q <= '0;
    end else begin
      evt_q   <= evt_i;
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      req_q   <= req_d;
      intx_q  <= intx_d;
      if (req_d) raddr_q <= raddr_d;
    end
  end

  assign req_o      = req_q;
  assign req_addr_o = raddr_q;
  assign intx_o     = intx_q;
endmodule

// File: rtl/msi_cap_sel.sv
module msi_cap_sel
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [OFF_W-1:0]  reg_off_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [BE_W-1:0]   reg_be_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              bme_i,
  input  logic              irq_evt_i,
  input  logic              irq_clr_i,
  input  logic              msi_ack_i,
  output logic              msi_req_o,
  output logic [DATA_W-1:0] msi_addr_o,
  output logic              intx_o
);
  logic              srst_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] cap_addr;
  logic              msi_en;

  msi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  msi_cap_regs u_regs (
    .clk(clk), .rst_n(srst_n), .wr_i(reg_wr_i), .off_i(reg_off_i),
    .wdata_i(reg_wdata_i), .be_i(reg_be_i), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl), .addr_o(cap_addr)
  );

  assign msi_en = ctrl.en;

  msi_cap_deliver u_dlv (
    .clk(clk), .rst_n(srst_n), .msi_en_i(msi_en), .bme_i(bme_i),
    .evt_i(irq_evt_i), .clr_i(irq_clr_i), .ack_i(msi_ack_i),
    .addr_i(cap_addr), .req_o(msi_req_o), .req_addr_o(msi_addr_o),
    .intx_o(intx_o)
  );
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msi_en,
  input logic        bme_i,
  input logic        irq_clr_i,
  input logic        msi_ack_i,
  input logic        msi_req_o,
  input logic [31:0] msi_addr_o,
  input logic        intx_o
);
  AST_REQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |-> $past(msi_en && bme_i)); // R8
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req_o && !msi_ack_i) |=> !msi_req_o); // R9
  AST_SILENT_NO_BME: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msi_en && !bme_i) |-> !msi_req_o); // R10
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |-> (msi_addr_o[1:0] == 2'b00)); // R6
  AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(intx_o && !irq_clr_i && !msi_en) |-> intx_o); // R11
  AST_NO_PIN_UNDER_MSI: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && $past(msi_en)) |-> !intx_o); // R12
endmodule

bind msi_cap_sel msi_cap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .bme_i(bme_i),
  .irq_clr_i(irq_clr_i), .msi_ack_i(msi_ack_i), .msi_req_o(msi_req_o),
  .msi_addr_o(msi_addr_o), .intx_o(intx_o)
);

// File: tb/test_msi_cap_sel.sv
module test_msi_cap_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_off;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_be;
  logic [31:0] reg_rdata;
  logic        bme, evt, clr, ack;
  logic        req;
  logic [31:0] req_addr;
  logic        intx;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  msi_cap_sel i_msi_cap_sel (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_off_i(reg_off),
    .reg_wdata_i(reg_wdata), .reg_be_i(reg_be), .reg_rdata_o(reg_rdata),
    .bme_i(bme), .irq_evt_i(evt), .irq_clr_i(clr), .msi_ack_i(ack),
    .msi_req_o(req), .msi_addr_o(req_addr), .intx_o(intx)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rd(input string rq, input logic [7:0] off, input logic [31:0] exp);
    reg_off = off;
    #1;
    check(rq, reg_rdata, exp);
  endtask

  // Raise event at a negedge; the request or pin shows at the following negedge.
  task automatic edge_evt();
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
  endtask

  task automatic ack_once();
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ctl_exp;
    logic [31:0] a_exp;
    rst_n = 1'b0; reg_wr = 0; reg_off = 0; reg_wdata = 0; reg_be = 0;
    bme = 0; evt = 0; clr = 0; ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd("R1", 8'h80, 32'h0000_9005);
    rd("R1", 8'h84, 32'h0000_0000);
    check("R1 req", {31'b0, req}, 32'd0);
    check("R1 intx", {31'b0, intx}, 32'd0);

    // R7 / R2 / R3 / R5 / R4: all-ones write to every doubleword, then read back
    for (int o = 0; o < 256; o += 4) begin
      wr(o[7:0], 32'hFFFF_FFFF, 4'hF);
      if (o == 8'h80)      rd("R2 R3 R4 R5 ones", o[7:0], 32'h0071_9005);
      else if (o == 8'h84) rd("R6 ones", o[7:0], 32'hFFFF_FFFC);
      else                 rd("R7 unmapped", o[7:0], 32'h0);
      wr(8'h80, 32'h0, 4'hF);
      wr(8'h84, 32'h0, 4'hF);
      if (o != 8'h80 && o != 8'h84) begin
        rd("R7 no side effect", 8'h80, 32'h0000_9005);
        rd("R7 no side effect", 8'h84, 32'h0);
      end
    end
    // R2: low half ignores writes with its own enables
    wr(8'h80, 32'h0000_0000, 4'h3);
    rd("R2 ro id", 8'h80, 32'h0000_9005);

    // R6 byte lanes
    for (int b = 0; b < 4; b++) begin
      wr(8'h84, 32'h0, 4'hF);
      wr(8'h84, 32'hA5A5_A5A7, 4'(1 << b));
      a_exp = (32'hA5A5_A5A7 & (32'hFF << (8*b))) & 32'hFFFF_FFFC;
      rd("R6 lane", 8'h84, a_exp);
    end

    // R4/R8: each MME value, one event, one request with address
    bme = 1'b1;
    for (int m = 0; m < 8; m++) begin
      a_exp = 32'h1000_0000 + 32'(m) * 32'h0404_0104;
      wr(8'h84, a_exp | 32'h3, 4'hF);
      ctl_exp = 32'h0001_0000 | (32'(m) << 20);
      wr(8'h80, ctl_exp, 4'h4);
      rd("R4 R5 ctl", 8'h80, ctl_exp | 32'h9005);
      @(negedge clk); evt = 1'b1;
      @(negedge clk);
      check("R8 req", {31'b0, req}, 32'd1);
      check("R8 addr", req_addr, a_exp & 32'hFFFF_FFFC);
      check("R12 pin", {31'b0, intx}, 32'd0);
      evt = 1'b0;
      @(negedge clk);
      check("R4 R8 single", {31'b0, req}, 32'd0);
      ack_once();
      repeat (2) @(negedge clk);
      check("R4 no extra", {31'b0, req}, 32'd0);
    end

    // R9 merging of edges while busy
    edge_evt();
    check("R9 first", {31'b0, req}, 32'd1);
    edge_evt();
    check("R9 held", {31'b0, req}, 32'd0);
    edge_evt();
    edge_evt();
    check("R9 held", {31'b0, req}, 32'd0);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R9 pending issued", {31'b0, req}, 32'd1);
    @(negedge clk);
    check("R9 single pulse", {31'b0, req}, 32'd0);
    ack_once();
    repeat (2) @(negedge clk);
    check("R9 merged to one", {31'b0, req}, 32'd0);

    // R10 no bus mastering
    bme = 1'b0;
    edge_evt();
    check("R10 req", {31'b0, req}, 32'd0);
    check("R10 pin", {31'b0, intx}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 req later", {31'b0, req}, 32'd0);
    check("R10 pin later", {31'b0, intx}, 32'd0);

    // R11 legacy pin, both bme values
    wr(8'h80, 32'h0, 4'h4);
    for (int bb = 0; bb < 2; bb++) begin
      bme = bb[0];
      @(negedge clk); evt = 1'b1;
      @(negedge clk); evt = 1'b0;
      check("R11 set", {31'b0, intx}, 32'd1);
      check("R11 no req", {31'b0, req}, 32'd0);
      repeat (5) @(negedge clk);
      check("R11 sticky", {31'b0, intx}, 32'd1);
      clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      check("R11 cleared", {31'b0, intx}, 32'd0);
    end

    // R12 enabling MSI drops a raised pin
    edge_evt();
    check("R12 pre", {31'b0, intx}, 32'd1);
    wr(8'h80, 32'h0001_0000, 4'h4);
    @(negedge clk);
    check("R12 dropped", {31'b0, intx}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule